// File: doc/BRIEF.md
# Inter-processor mailbox register pair

This block links a host processor to a security coprocessor through two one-word channels, one for each direction. The host sends a word by writing it into the inbound slot. The coprocessor sees the word together with an interrupt. When it takes the word it pulses a consume strobe, and the slot returns to zero. The host polls the slot until it reads zero, which tells it the word was taken.

The other channel works the opposite way. The coprocessor loads a word into the outbound slot, but only when that slot is zero. The host reads the slot. A zero read means nothing is waiting. To acknowledge a nonzero word, the host writes that exact word back. In both directions zero is the "empty" or "taken" marker.

Three argument registers sit beside the inbound slot. The host can read and write them, and the coprocessor can write them. Two sticky error flags record two host mistakes: writing into a slot that is still full, and echoing back the wrong word. Decoding of commands is left to the coprocessor firmware.

Top module: `ipc_mailbox`

## Requirements
- R1: Synchronous active-high reset clears both slots, all argument registers and both sticky flags. After reset the interrupts are low, `out_empty` is high and every mapped offset reads zero.
- R2: A host write of a nonzero word to offset 0x10 while the inbound slot is zero stores the word. The word appears on `c_in_word` and reads back at 0x10 from the next cycle.
- R3: A `c_consume` pulse while the inbound slot is nonzero clears the slot to zero by the next cycle.
- R4: A host write of a nonzero word to 0x10 while the inbound slot is nonzero is dropped and the slot is unchanged. It sets `err_overrun`, which stays set until reset.
- R5: A host write of zero to 0x10 has no effect on the slot or on the flags.
- R6: `c_load_ok` is high in the same cycle as `c_load` exactly when the outbound slot is zero, and the slot then takes `c_load_data`. A load into a nonzero slot leaves the slot unchanged.
- R7: Offset 0x00 reads the outbound slot, and reads zero when the slot is empty.
- R8: A host write to 0x00 whose data equals the pending outbound word clears the slot, so `out_empty` is high on the next cycle.
- R9: A host write to 0x00 whose data differs from the slot content leaves the slot unchanged. It sets `err_ack`, which stays set until reset.
- R10: `irq_cop` is high exactly while the inbound slot is nonzero. `irq_host` is high exactly while the outbound slot is nonzero.
- R11: Offsets 0x14, 0x18 and 0x1C are argument registers 0, 1 and 2, and the host can read and write each one. The coprocessor writes argument `c_arg_sel` through `c_arg_wr`. If the host writes the same argument in the same cycle, the host wins. A select of 3 or more is ignored. Argument i is driven on `c_args[32*i +: 32]`.
- R12: `c_cmd_flag` follows bit 0 of the inbound slot. This bit is the command valid flag.
- R13: Offset 0x20 reads the status word: bit 0 is `err_overrun`, bit 1 is `err_ack`, and all other bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| h_wr_en | input | 1 | Host write strobe |
| h_addr | input | 8 | Host byte offset |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data for `h_addr` (combinational) |
| c_in_word | output | 32 | Current inbound slot |
| c_cmd_flag | output | 1 | Bit 0 of the inbound slot |
| c_consume | input | 1 | Coprocessor strobe that takes the inbound word |
| c_load | input | 1 | Coprocessor request to fill the outbound slot |
| c_load_data | input | 32 | Word offered to the outbound slot |
| c_load_ok | output | 1 | The load in this cycle is accepted |
| c_arg_wr | input | 1 | Coprocessor argument write strobe |
| c_arg_sel | input | 2 | Argument index for the coprocessor write |
| c_arg_wdata | input | 32 | Coprocessor argument data |
| c_args | output | 96 | All argument registers, argument 0 in the low bits |
| irq_cop | output | 1 | Level interrupt to the coprocessor |
| irq_host | output | 1 | Level interrupt to the host |
| out_empty | output | 1 | Outbound slot is zero |
| err_overrun | output | 1 | Sticky flag: host wrote into a full inbound slot |
| err_ack | output | 1 | Sticky flag: acknowledge did not match |

## Verification
The bench drives the host channel with four kinds of write:
- a fresh nonzero word;
- a second word while the first is still pending;
- a zero word;
- acknowledges that either match the pending outbound word or differ from it in one bit.

These separate a store from an overrun, from a no-op and from an error. Loads into an empty outbound slot and into a full one show whether the accept test uses the slot's present value. Words with bit 0 set and clear exercise the command flag. Host and coprocessor writes land on the same argument in the same cycle, which exposes the write priority. An out-of-range select shows whether it is masked.

// File: rtl/ipc_mailbox_pkg.sv
package ipc_mailbox_pkg;

    // Host register offsets (byte addresses)
    localparam int unsigned OFS_OUTBOX = 32'h00;
    localparam int unsigned OFS_INBOX  = 32'h10;
    localparam int unsigned OFS_ARG0   = 32'h14;
    localparam int unsigned ARG_STRIDE = 32'h04;
    localparam int unsigned OFS_STATUS = 32'h20;

    // Status word bit positions
    localparam int unsigned STAT_OVERRUN_BIT = 0;
    localparam int unsigned STAT_ACK_BIT     = 1;

    function automatic int unsigned arg_offset(input int unsigned idx);
        return OFS_ARG0 + idx * ARG_STRIDE;
    endfunction

endpackage

// File: rtl/mbx_in_slot.sv
// Host-to-coprocessor slot with overrun detection
module mbx_in_slot #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_wr,
    input  logic [DATA_W-1:0] host_data,
    input  logic              consume,
    output logic [DATA_W-1:0] word,
    output logic              overrun
);

    typedef struct packed {
        logic [DATA_W-1:0] word;
        logic              overrun;
    } in_state_t;

    in_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (consume) begin
            s_d.word = '0;
        end
        // zero from the host is a no-op and never an overrun
        if (host_wr && (host_data != '0)) begin
            if (s_q.word == '0) begin
                s_d.word = host_data;
            end else begin
                s_d.overrun = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign word    = s_q.word;
    assign overrun = s_q.overrun;

endmodule

// File: rtl/mbx_out_slot.sv
// Coprocessor-to-host slot, acknowledged by echoing the word back
module mbx_out_slot #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    output logic              load_ok,
    input  logic              ack_wr,
    input  logic [DATA_W-1:0] ack_data,
    output logic [DATA_W-1:0] word,
    output logic              ack_err
);

    typedef struct packed {
        logic [DATA_W-1:0] word;
        logic              ack_err;
    } out_state_t;

    out_state_t s_d, s_q;
    logic       slot_free;

    assign slot_free = (s_q.word == '0);
    assign load_ok   = load && slot_free;

    always_comb begin
        s_d = s_q;
        if (ack_wr) begin
            if (ack_data == s_q.word) begin
                s_d.word = '0;
            end else begin
                s_d.ack_err = 1'b1;
            end
        end
        // accepted only into a free slot, so it never collides with a clearing ack
        if (load_ok) begin
            s_d.word = load_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign word    = s_q.word;
    assign ack_err = s_q.ack_err;

endmodule

// File: rtl/mbx_arg_bank.sv
// Argument registers written by host or coprocessor; host has priority
module mbx_arg_bank #(
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned NUM_ARGS  = 3,
    parameter int unsigned ARG_SEL_W = 2
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [NUM_ARGS-1:0]          host_wr,
    input  logic [DATA_W-1:0]            host_data,
    input  logic                         cop_wr,
    input  logic [ARG_SEL_W-1:0]         cop_sel,
    input  logic [DATA_W-1:0]            cop_data,
    output logic [NUM_ARGS*DATA_W-1:0]   args
);

    typedef struct packed {
        logic [NUM_ARGS-1:0][DATA_W-1:0] arg;
    } arg_state_t;

    arg_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        for (int i = 0; i < NUM_ARGS; i++) begin
            if (host_wr[i]) begin
                s_d.arg[i] = host_data;
            end else if (cop_wr && (int'(cop_sel) == i)) begin
                s_d.arg[i] = cop_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    for (genvar g = 0; g < NUM_ARGS; g++) begin : g_arg_out
        assign args[g*DATA_W +: DATA_W] = s_q.arg[g];
    end

endmodule

// File: rtl/mbx_host_decode.sv
// Host offset decode and read-data multiplexer
module mbx_host_decode
    import ipc_mailbox_pkg::*;
#(
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned NUM_ARGS = 3
) (
    input  logic                        wr_en,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [DATA_W-1:0]           in_word,
    input  logic [DATA_W-1:0]           out_word,
    input  logic [NUM_ARGS*DATA_W-1:0]  args,
    input  logic                        overrun,
    input  logic                        ack_err,
    output logic                        inbox_wr,
    output logic                        outbox_wr,
    output logic [NUM_ARGS-1:0]         arg_wr,
    output logic [DATA_W-1:0]           rdata
);

    localparam logic [ADDR_W-1:0] A_OUTBOX = ADDR_W'(OFS_OUTBOX);
    localparam logic [ADDR_W-1:0] A_INBOX  = ADDR_W'(OFS_INBOX);
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFS_STATUS);

    logic [DATA_W-1:0] status_word;

    always_comb begin
        status_word = '0;
        status_word[STAT_OVERRUN_BIT] = overrun;
        status_word[STAT_ACK_BIT]     = ack_err;
    end

    assign inbox_wr  = wr_en && (addr == A_INBOX);
    assign outbox_wr = wr_en && (addr == A_OUTBOX);

    for (genvar g = 0; g < NUM_ARGS; g++) begin : g_arg_hit
        assign arg_wr[g] = wr_en && (addr == ADDR_W'(arg_offset(g)));
    end

    always_comb begin
        rdata = '0;
        if (addr == A_OUTBOX) begin
            rdata = out_word;
        end else if (addr == A_INBOX) begin
            rdata = in_word;
        end else if (addr == A_STATUS) begin
            rdata = status_word;
        end else begin
            for (int i = 0; i < NUM_ARGS; i++) begin
                if (addr == ADDR_W'(arg_offset(i))) begin
                    rdata = args[i*DATA_W +: DATA_W];
                end
            end
        end
    end

endmodule

// File: rtl/ipc_mailbox.sv
// Host/coprocessor mailbox: one word each way, zero means empty
module ipc_mailbox #(
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned NUM_ARGS  = 3,
    parameter int unsigned ARG_SEL_W = (NUM_ARGS > 1) ? $clog2(NUM_ARGS) : 1
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        h_wr_en,
    input  logic [ADDR_W-1:0]           h_addr,
    input  logic [DATA_W-1:0]           h_wdata,
    output logic [DATA_W-1:0]           h_rdata,
    output logic [DATA_W-1:0]           c_in_word,
    output logic                        c_cmd_flag,
    input  logic                        c_consume,
    input  logic                        c_load,
    input  logic [DATA_W-1:0]           c_load_data,
    output logic                        c_load_ok,
    input  logic                        c_arg_wr,
    input  logic [ARG_SEL_W-1:0]        c_arg_sel,
    input  logic [DATA_W-1:0]           c_arg_wdata,
    output logic [NUM_ARGS*DATA_W-1:0]  c_args,
    output logic                        irq_cop,
    output logic                        irq_host,
    output logic                        out_empty,
    output logic                        err_overrun,
    output logic                        err_ack
);

    logic                inbox_wr;
    logic                outbox_wr;
    logic [NUM_ARGS-1:0] arg_wr;
    logic [DATA_W-1:0]   in_word;
    logic [DATA_W-1:0]   out_word;

    mbx_host_decode #(
        .DATA_W   (DATA_W),
        .ADDR_W   (ADDR_W),
        .NUM_ARGS (NUM_ARGS)
    ) i_decode (
        .wr_en     (h_wr_en),
        .addr      (h_addr),
        .in_word   (in_word),
        .out_word  (out_word),
        .args      (c_args),
        .overrun   (err_overrun),
        .ack_err   (err_ack),
        .inbox_wr  (inbox_wr),
        .outbox_wr (outbox_wr),
        .arg_wr    (arg_wr),
        .rdata     (h_rdata)
    );

    mbx_in_slot #(
        .DATA_W (DATA_W)
    ) i_in_slot (
        .clk       (clk),
        .rst       (rst),
        .host_wr   (inbox_wr),
        .host_data (h_wdata),
        .consume   (c_consume),
        .word      (in_word),
        .overrun   (err_overrun)
    );

    mbx_out_slot #(
        .DATA_W (DATA_W)
    ) i_out_slot (
        .clk       (clk),
        .rst       (rst),
        .load      (c_load),
        .load_data (c_load_data),
        .load_ok   (c_load_ok),
        .ack_wr    (outbox_wr),
        .ack_data  (h_wdata),
        .word      (out_word),
        .ack_err   (err_ack)
    );

    mbx_arg_bank #(
        .DATA_W    (DATA_W),
        .NUM_ARGS  (NUM_ARGS),
        .ARG_SEL_W (ARG_SEL_W)
    ) i_args (
        .clk       (clk),
        .rst       (rst),
        .host_wr   (arg_wr),
        .host_data (h_wdata),
        .cop_wr    (c_arg_wr),
        .cop_sel   (c_arg_sel),
        .cop_data  (c_arg_wdata),
        .args      (c_args)
    );

    assign c_in_word  = in_word;
    assign c_cmd_flag = in_word[0];
    assign irq_cop    = (in_word != '0);
    assign out_empty  = (out_word == '0);
    assign irq_host   = !out_empty;

endmodule

// File: rtl/mbx_checker.sv
module mbx_checker
    import ipc_mailbox_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              h_wr_en,
    input logic [ADDR_W-1:0] h_addr,
    input logic [DATA_W-1:0] h_wdata,
    input logic [DATA_W-1:0] in_word,
    input logic [DATA_W-1:0] out_word,
    input logic              consume,
    input logic              load,
    input logic              cop_arg_wr,
    input logic              cop_arg_sel0,
    input logic [DATA_W-1:0] arg0,
    input logic              out_empty,
    input logic              overrun,
    input logic              ack_err
);

    logic wr_inbox, wr_outbox, wr_arg0;
    assign wr_inbox  = h_wr_en && (h_addr == ADDR_W'(OFS_INBOX));
    assign wr_outbox = h_wr_en && (h_addr == ADDR_W'(OFS_OUTBOX));
    assign wr_arg0   = h_wr_en && (h_addr == ADDR_W'(OFS_ARG0));

    // R3
    consume_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (consume && (in_word != '0)) |=> (in_word == '0));

    // R4
    overrun_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_inbox && (h_wdata != '0) && (in_word != '0) && !consume)
        |=> ((in_word == $past(in_word)) && overrun));

    // R4
    overrun_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        overrun |=> overrun);

    // R6
    load_reject_chk: assert property (@(posedge clk) disable iff (rst)
        (load && (out_word != '0) && !wr_outbox) |=> $stable(out_word));

    // R8
    ack_match_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_outbox && (out_word != '0) && (h_wdata == out_word)) |=> out_empty);

    // R9
    ack_mismatch_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_outbox && (out_word != '0) && (h_wdata != out_word))
        |=> ($stable(out_word) && ack_err));

    // R9
    ack_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        ack_err |=> ack_err);

    // R11
    arg_host_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_arg0 && cop_arg_wr && cop_arg_sel0) |=> (arg0 == $past(h_wdata)));

endmodule

bind ipc_mailbox mbx_checker #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
) i_chk (
    .clk          (clk),
    .rst          (rst),
    .h_wr_en      (h_wr_en),
    .h_addr       (h_addr),
    .h_wdata      (h_wdata),
    .in_word      (in_word),
    .out_word     (out_word),
    .consume      (c_consume),
    .load         (c_load),
    .cop_arg_wr   (c_arg_wr),
    .cop_arg_sel0 (c_arg_sel == '0),
    .arg0         (c_args[DATA_W-1:0]),
    .out_empty    (out_empty),
    .overrun      (err_overrun),
    .ack_err      (err_ack)
);

// File: tb/test_ipc_mailbox.sv
module test_ipc_mailbox;

    localparam int CLK_PERIOD = 10;

    // op: 0 host write 0x10, 1 host write 0x00, 2 consume, 3 coprocessor load
    typedef struct packed {
        logic [3:0]  req;
        logic [1:0]  op;
        logic [31:0] data;
        logic [31:0] exp_in;
        logic [31:0] exp_out;
        logic [1:0]  exp_err;   // {ack error, overrun}
    } vec_t;

    localparam int NVEC = 12;
    localparam vec_t VECS [NVEC] = '{
        '{4'd2,  2'd0, 32'h0000_0031, 32'h0000_0031, 32'h0,          2'b00}, // R2 store
        '{4'd4,  2'd0, 32'h0000_0055, 32'h0000_0031, 32'h0,          2'b01}, // R4 overrun
        '{4'd3,  2'd2, 32'h0,         32'h0,         32'h0,          2'b01}, // R3 consume
        '{4'd5,  2'd0, 32'h0,         32'h0,         32'h0,          2'b01}, // R5 zero no-op
        '{4'd2,  2'd0, 32'hA5A5_0001, 32'hA5A5_0001, 32'h0,          2'b01}, // R2 store again
        '{4'd6,  2'd3, 32'h1234_5678, 32'hA5A5_0001, 32'h1234_5678, 2'b01}, // R6 load accepted
        '{4'd6,  2'd3, 32'h0000_1111, 32'hA5A5_0001, 32'h1234_5678, 2'b01}, // R6 load rejected
        '{4'd9,  2'd1, 32'h1234_5679, 32'hA5A5_0001, 32'h1234_5678, 2'b11}, // R9 mismatch
        '{4'd8,  2'd1, 32'h1234_5678, 32'hA5A5_0001, 32'h0,          2'b11}, // R8 match
        '{4'd6,  2'd3, 32'h0BAD_F00D, 32'hA5A5_0001, 32'h0BAD_F00D, 2'b11}, // R6 load
        '{4'd3,  2'd2, 32'h0,         32'h0,         32'h0BAD_F00D, 2'b11}, // R3 consume
        '{4'd8,  2'd1, 32'h0BAD_F00D, 32'h0,         32'h0,          2'b11}  // R8 match
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        h_wr_en;
    logic [7:0]  h_addr;
    logic [31:0] h_wdata;
    logic [31:0] h_rdata;
    logic [31:0] c_in_word;
    logic        c_cmd_flag;
    logic        c_consume;
    logic        c_load;
    logic [31:0] c_load_data;
    logic        c_load_ok;
    logic        c_arg_wr;
    logic [1:0]  c_arg_sel;
    logic [31:0] c_arg_wdata;
    logic [95:0] c_args;
    logic        irq_cop;
    logic        irq_host;
    logic        out_empty;
    logic        err_overrun;
    logic        err_ack;

    int n_chk = 0;
    int n_err = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ipc_mailbox i_ipc_mailbox (
        .clk         (clk),
        .rst         (rst),
        .h_wr_en     (h_wr_en),
        .h_addr      (h_addr),
        .h_wdata     (h_wdata),
        .h_rdata     (h_rdata),
        .c_in_word   (c_in_word),
        .c_cmd_flag  (c_cmd_flag),
        .c_consume   (c_consume),
        .c_load      (c_load),
        .c_load_data (c_load_data),
        .c_load_ok   (c_load_ok),
        .c_arg_wr    (c_arg_wr),
        .c_arg_sel   (c_arg_sel),
        .c_arg_wdata (c_arg_wdata),
        .c_args      (c_args),
        .irq_cop     (irq_cop),
        .irq_host    (irq_host),
        .out_empty   (out_empty),
        .err_overrun (err_overrun),
        .err_ack     (err_ack)
    );

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        h_addr = a;
        #1;
        d = h_rdata;
    endtask

    task automatic idle_inputs();
        h_wr_en = 1'b0; c_consume = 1'b0; c_load = 1'b0; c_arg_wr = 1'b0;
    endtask

    task automatic apply(input logic [1:0] op, input logic [31:0] data);
        @(negedge clk);
        case (op)
            2'd0: begin h_wr_en = 1'b1; h_addr = 8'h10; h_wdata = data; end
            2'd1: begin h_wr_en = 1'b1; h_addr = 8'h00; h_wdata = data; end
            2'd2: c_consume = 1'b1;
            default: begin c_load = 1'b1; c_load_data = data; end
        endcase
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic host_wr(input logic [7:0] a, input logic [31:0] data);
        @(negedge clk);
        h_wr_en = 1'b1; h_addr = a; h_wdata = data;
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    task automatic chk_reset_state(input string tag);
        logic [31:0] d;
        chk({tag, " inbound word"}, c_in_word, 32'h0);
        rd(8'h00, d); chk({tag, " read 0x00"}, d, 32'h0);
        rd(8'h10, d); chk({tag, " read 0x10"}, d, 32'h0);
        rd(8'h20, d); chk({tag, " read status"}, d, 32'h0);
        rd(8'h18, d); chk({tag, " read arg1"}, d, 32'h0);
        chk({tag, " irqs/empty"}, {29'h0, irq_cop, irq_host, out_empty}, 32'h1);
        chk({tag, " args"}, c_args[31:0] | c_args[63:32] | c_args[95:64], 32'h0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=hung expected=done");
        report();
        $finish;
    end

    initial begin
        logic [31:0] d;
        rst = 1'b1;
        h_addr = 8'h00; h_wdata = '0; c_load_data = '0;
        c_arg_sel = '0; c_arg_wdata = '0;
        idle_inputs();
        do_reset();

        // R1 reset state
        chk_reset_state("R1 after reset");

        // table of host and coprocessor operations, R2..R9
        for (int i = 0; i < NVEC; i++) begin
            apply(VECS[i].op, VECS[i].data);
            chk($sformatf("R%0d vec %0d inbound", VECS[i].req, i), c_in_word, VECS[i].exp_in);
            rd(8'h00, d);
            chk($sformatf("R7 vec %0d read 0x00", i), d, VECS[i].exp_out);
            chk($sformatf("R%0d vec %0d flags", VECS[i].req, i),
                {30'h0, err_ack, err_overrun}, {30'h0, VECS[i].exp_err});
        end

        // R6 accept strobe seen in the same cycle, R10 host interrupt
        @(negedge clk);
        c_load = 1'b1; c_load_data = 32'h0000_0077;
        #1 chk("R6 load_ok into empty slot", {31'h0, c_load_ok}, 32'h1);
        @(negedge clk);
        idle_inputs();
        chk("R10 irq_host with word pending", {31'h0, irq_host}, 32'h1);
        chk("R8 out_empty low with word pending", {31'h0, out_empty}, 32'h0);
        @(negedge clk);
        c_load = 1'b1; c_load_data = 32'h0000_0099;
        #1 chk("R6 load_ok into full slot", {31'h0, c_load_ok}, 32'h0);
        @(negedge clk);
        idle_inputs();
        rd(8'h00, d); chk("R6 full slot kept", d, 32'h0000_0077);

        // R12 command flag, R10 coprocessor interrupt
        host_wr(8'h10, 32'h0000_0002);
        chk("R12 flag with bit0 clear", {31'h0, c_cmd_flag}, 32'h0);
        chk("R10 irq_cop with word pending", {31'h0, irq_cop}, 32'h1);
        apply(2'd2, 32'h0);
        chk("R10 irq_cop after consume", {31'h0, irq_cop}, 32'h0);
        host_wr(8'h10, 32'h0000_0003);
        chk("R12 flag with bit0 set", {31'h0, c_cmd_flag}, 32'h1);
        rd(8'h10, d); chk("R2 read back 0x10", d, 32'h0000_0003);

        // R11 argument registers
        host_wr(8'h14, 32'hAAAA_0000);
        host_wr(8'h18, 32'hBBBB_0000);
        host_wr(8'h1C, 32'hCCCC_0000);
        rd(8'h14, d); chk("R11 arg0 read", d, 32'hAAAA_0000);
        rd(8'h1C, d); chk("R11 arg2 read", d, 32'hCCCC_0000);
        @(negedge clk);
        c_arg_wr = 1'b1; c_arg_sel = 2'd1; c_arg_wdata = 32'hDDDD_0000;
        @(negedge clk);
        idle_inputs();
        rd(8'h18, d); chk("R11 coprocessor write arg1", d, 32'hDDDD_0000);
        chk("R11 c_args arg1 field", c_args[63:32], 32'hDDDD_0000);
        @(negedge clk);
        h_wr_en = 1'b1; h_addr = 8'h1C; h_wdata = 32'hEEEE_0000;
        c_arg_wr = 1'b1; c_arg_sel = 2'd2; c_arg_wdata = 32'hFFFF_0000;
        @(negedge clk);
        idle_inputs();
        rd(8'h1C, d); chk("R11 host wins same argument", d, 32'hEEEE_0000);
        @(negedge clk);
        c_arg_wr = 1'b1; c_arg_sel = 2'd3; c_arg_wdata = 32'h1357_9BDF;
        @(negedge clk);
        idle_inputs();
        chk("R11 select 3 ignored arg0", c_args[31:0], 32'hAAAA_0000);
        chk("R11 select 3 ignored arg1", c_args[63:32], 32'hDDDD_0000);
        chk("R11 select 3 ignored arg2", c_args[95:64], 32'hEEEE_0000);

        // R13 status word
        rd(8'h20, d); chk("R13 status bits", d, 32'h0000_0003);

        // R1 second reset clears everything, sticky flags included
        do_reset();
        chk_reset_state("R1 after second reset");

        report();
        $finish;
    end

endmodule